// File: doc/BRIEF.md
# Wrapping Acquisition Memory Controller

This block captures a stream of 32-bit samples, together with an 8-bit glitch flag word for each sample, into a pair of 256-entry circular memories. Both memories share one write address. That address comes from a chain of 4-bit counter stages and advances once for every accepted write strobe. When the address rolls over from its last entry back to zero, a sticky wrap flag is set. The flag tells the host that the whole buffer holds valid history. In that case the oldest sample sits at the current write address. Without a wrap, the valid samples run from address 0 up to the write address minus one.

A stop request freezes acquisition. Later strobes neither write nor move the address. This continues until reset. Reset clears the address, the wrap flag and the stop state, but the captured contents are kept.

A host port reads back any entry of either memory, or a status word, through one output selector. It uses its own read address. Each result appears one cycle after the request, with a valid flag.

Top module: `acq_mem_top`

## Requirements
- R1: After reset the write address is 0, the wrap flag and the stopped bit are clear, and hostValid is low.
- R2: Each accepted write strobe stores wrData and wrGlitch at the current write address. The address then advances by one, modulo 256.
- R3: The wrap flag is set when an accepted write occurs at address 255. It stays set until reset.
- R4: A stopReq pulse sets the stopped state, which stays set until reset. A strobe in the stopReq cycle or in any later cycle writes nothing and leaves the address unchanged.
- R5: A hostRd in one cycle gives hostValid high on the next cycle, with the selected result on hostData. Without a request, hostValid is low and hostData is zero.
- R6: hostSel selects the source. 0 selects sample data. 1 selects glitch flags in bits 7:0 with the upper bits zero. 2 selects the status word. 3 returns zero.
- R7: In the status word, bits 7:0 hold the write address, bit 8 the wrap flag and bit 9 the stopped bit. All other bits are zero. The word reflects the state in the cycle the read is issued.
- R8: Reset leaves the contents of both memories unchanged.
- R9: A host read of the address being written in the same cycle returns the contents from before that write.
- R10: After a wrap, the entry at the current write address is the oldest sample kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrStrobe | input | 1 | Write one sample this cycle |
| wrData | input | 32 | Sample data word |
| wrGlitch | input | 8 | Glitch flags for the sample |
| stopReq | input | 1 | Stop acquisition (sticky) |
| hostRd | input | 1 | Host read request |
| hostSel | input | 2 | Read source select |
| hostAddr | input | 8 | Host read address |
| hostData | output | 32 | Read result |
| hostValid | output | 1 | Read result valid |

## Verification
Every host read result is due exactly one clock after the request edge. Write, stop and reset effects become visible to a read issued on the next cycle. The bench drives stimulus on falling edges and pushes each expected word when the request is driven. The monitor samples shortly after the following rising edge and pops one entry for each valid result. A result that arrives late, early or unasked shows up as a mismatch. The expected words come from a model memory and counter that the bench keeps itself.

// File: rtl/acq_mem_pkg.sv
package acq_mem_pkg;
  typedef enum logic [1:0] {
    SEL_SAMPLE = 2'd0,
    SEL_GLITCH = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_NONE   = 2'd3
  } hostSel_e;

  typedef struct packed {
    logic     wrEn;
    logic     rdEn;
    hostSel_e rdSel;
  } acqStrobes_t;
endpackage

// File: rtl/acq_addr_nibble.sv
module acq_addr_nibble #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inc,
  output logic [NIB_W-1:0] q,
  output logic             carryOut
);
  localparam logic [NIB_W-1:0] FULL = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= '0;
    else if (inc) q <= q + 1'b1;
  end

  assign carryOut = inc && (q == FULL);
endmodule

// File: rtl/acq_mem_ctrl.sv
module acq_mem_ctrl
  import acq_mem_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic              stopReq,
  input  logic              hostRd,
  input  logic [1:0]        hostSel,
  output acqStrobes_t       strobes,
  output logic [ADDR_W-1:0] curAddr,
  output logic              carryFlag,
  output logic              stopped
);
  localparam int NUM_NIB = ADDR_W / NIB_W;

  logic [NUM_NIB:0] stageEn;
  logic             wrEn;

  assign wrEn = wrStrobe && !stopped && !stopReq;
  assign stageEn[0] = wrEn;

  for (genvar i = 0; i < NUM_NIB; i++) begin : g_stage
    acq_addr_nibble #(.NIB_W(NIB_W)) u_nib (
      .clk      (clk),
      .rstN     (rstN),
      .inc      (stageEn[i]),
      .q        (curAddr[i*NIB_W +: NIB_W]),
      .carryOut (stageEn[i+1])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryFlag <= 1'b0;
      stopped   <= 1'b0;
    end else begin
      if (stageEn[NUM_NIB]) carryFlag <= 1'b1;
      if (stopReq) stopped <= 1'b1;
    end
  end

  always_comb begin
    strobes.wrEn  = wrEn;
    strobes.rdEn  = hostRd;
    strobes.rdSel = hostSel_e'(hostSel);
  end
endmodule

// File: rtl/acq_mem_datapath.sv
module acq_mem_datapath
  import acq_mem_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int GLITCH_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  acqStrobes_t         strobes,
  input  logic [ADDR_W-1:0]   curAddr,
  input  logic                carryFlag,
  input  logic                stopped,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [GLITCH_W-1:0] wrGlitch,
  input  logic [ADDR_W-1:0]   hostAddr,
  output logic [DATA_W-1:0]   hostData,
  output logic                hostValid
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0]   sampleMem [DEPTH];
  logic [GLITCH_W-1:0] glitchMem [DEPTH];
  logic [DATA_W-1:0]   sampleQ, statusQ, statusWord;
  logic [GLITCH_W-1:0] glitchQ;
  hostSel_e            selQ;
  logic                validQ;

  always_comb begin
    statusWord = '0;
    statusWord[ADDR_W-1:0] = curAddr;
    statusWord[ADDR_W]     = carryFlag;
    statusWord[ADDR_W+1]   = stopped;
  end

  // Memories carry no reset; reads are read-before-write.
  always_ff @(posedge clk) begin
    if (strobes.wrEn) begin
      sampleMem[curAddr] <= wrData;
      glitchMem[curAddr] <= wrGlitch;
    end
    if (strobes.rdEn) begin
      sampleQ <= sampleMem[hostAddr];
      glitchQ <= glitchMem[hostAddr];
      statusQ <= statusWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
      selQ   <= SEL_NONE;
    end else begin
      validQ <= strobes.rdEn;
      if (strobes.rdEn) selQ <= strobes.rdSel;
    end
  end

  always_comb begin
    hostData = '0;
    if (validQ) begin
      unique case (selQ)
        SEL_SAMPLE: hostData = sampleQ;
        SEL_GLITCH: hostData[GLITCH_W-1:0] = glitchQ;
        SEL_STATUS: hostData = statusQ;
        default:    hostData = '0;
      endcase
    end
  end

  assign hostValid = validQ;
endmodule

// File: rtl/acq_mem_top.sv
module acq_mem_top
  import acq_mem_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NIB_W    = 4,
  parameter int DATA_W   = 32,
  parameter int GLITCH_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrStrobe,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [GLITCH_W-1:0] wrGlitch,
  input  logic                stopReq,
  input  logic                hostRd,
  input  logic [1:0]          hostSel,
  input  logic [ADDR_W-1:0]   hostAddr,
  output logic [DATA_W-1:0]   hostData,
  output logic                hostValid
);
  acqStrobes_t       strobes;
  logic [ADDR_W-1:0] curAddr;
  logic              carryFlag;
  logic              stopped;
  logic              wrEnInt;

  assign wrEnInt = strobes.wrEn;

  acq_mem_ctrl #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrStrobe  (wrStrobe),
    .stopReq   (stopReq),
    .hostRd    (hostRd),
    .hostSel   (hostSel),
    .strobes   (strobes),
    .curAddr   (curAddr),
    .carryFlag (carryFlag),
    .stopped   (stopped)
  );

  acq_mem_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GLITCH_W(GLITCH_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .curAddr   (curAddr),
    .carryFlag (carryFlag),
    .stopped   (stopped),
    .wrData    (wrData),
    .wrGlitch  (wrGlitch),
    .hostAddr  (hostAddr),
    .hostData  (hostData),
    .hostValid (hostValid)
  );
endmodule

// File: rtl/acq_mem_checks.sv
module acq_mem_checks #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              stopReq,
  input logic              hostRd,
  input logic [ADDR_W-1:0] curAddr,
  input logic              carryFlag,
  input logic              stopped,
  input logic [DATA_W-1:0] hostData,
  input logic              hostValid
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  assert_addr_advance_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> curAddr == ADDR_W'($past(curAddr) + 1'b1));

  assert_wrap_sets_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && curAddr == LAST) |=> carryFlag);

  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    carryFlag |=> carryFlag);

  assert_stop_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> stopped);

  assert_stop_freeze_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stopped || stopReq) |=> $stable(curAddr));

  assert_read_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    hostRd |=> hostValid);

  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rstN)
    !hostRd |=> !hostValid);

  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    !hostValid |-> hostData == '0);
endmodule

bind acq_mem_top acq_mem_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checks (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEnInt),
  .stopReq   (stopReq),
  .hostRd    (hostRd),
  .curAddr   (curAddr),
  .carryFlag (carryFlag),
  .stopped   (stopped),
  .hostData  (hostData),
  .hostValid (hostValid)
);

// File: tb/acq_mem_top_bench.sv
`timescale 1ns/1ps
module acq_mem_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStrobe = 1'b0;
  logic [31:0] wrData = '0;
  logic [7:0]  wrGlitch = '0;
  logic        stopReq = 1'b0;
  logic        hostRd = 1'b0;
  logic [1:0]  hostSel = '0;
  logic [7:0]  hostAddr = '0;
  logic [31:0] hostData;
  logic        hostValid;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  logic [31:0] mData [256];
  logic [7:0]  mGlitch [256];
  logic [7:0]  mAddr = '0;
  bit          mCarry = 0;
  bit          mStopped = 0;
  int          wrCount = 0;

  always #2 clk = ~clk;

  acq_mem_top u_acq_mem_top (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrData(wrData),
    .wrGlitch(wrGlitch), .stopReq(stopReq), .hostRd(hostRd),
    .hostSel(hostSel), .hostAddr(hostAddr), .hostData(hostData),
    .hostValid(hostValid)
  );

  function automatic logic [31:0] statusOf();
    return {22'd0, mStopped, mCarry, mAddr};
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: results are due one edge after the request.
  always @(posedge clk) begin
    #1;
    if (hostValid) begin
      if (expQ.size() == 0) check(hostData, 32'hDEAD_0000, "R5 unexpected result");
      else check(hostData, expQ.pop_front(), tagQ.pop_front());
    end else if (expQ.size() != 0) begin
      check({31'd0, hostValid}, 32'd1, {tagQ.pop_front(), " (R5 missing valid)"});
      void'(expQ.pop_front());
    end
  end

  task automatic doWrite(input logic [31:0] d, input logic [7:0] g);
    @(negedge clk);
    wrStrobe = 1'b1; wrData = d; wrGlitch = g;
    @(negedge clk);
    wrStrobe = 1'b0;
    if (!mStopped) begin
      mData[mAddr] = d; mGlitch[mAddr] = g;
      if (mAddr == 8'hFF) mCarry = 1;
      mAddr = mAddr + 8'd1;
    end
  endtask

  task automatic doRead(input logic [1:0] sel, input logic [7:0] a, input string tag);
    logic [31:0] e;
    case (sel)
      2'd0: e = mData[a];
      2'd1: e = {24'd0, mGlitch[a]};
      2'd2: e = statusOf();
      default: e = '0;
    endcase
    @(negedge clk);
    hostRd = 1'b1; hostSel = sel; hostAddr = a;
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mAddr = '0; mCarry = 0; mStopped = 0;
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'hA500_0000 ^ (i * 32'h0101_0137);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check({31'd0, hostValid}, 32'd0, "R1 hostValid after reset");
    check(hostData, 32'd0, "R5 idle hostData zero");
    doRead(2'd2, 8'd0, "R1 R7 status after reset");

    for (int i = 0; i < 10; i++) begin
      doWrite(pat(wrCount), 8'(wrCount * 3) ^ 8'h5A); wrCount++;
    end
    for (int i = 0; i < 10; i++) doRead(2'd0, 8'(i), "R2 R6 sample readback");
    for (int i = 0; i < 10; i++) doRead(2'd1, 8'(i), "R2 R6 glitch readback");
    doRead(2'd2, 8'd0, "R7 status after 10 writes");
    doRead(2'd3, 8'd3, "R6 unused select returns zero");

    // Back-to-back reads
    @(negedge clk);
    hostRd = 1'b1; hostSel = 2'd0; hostAddr = 8'd1;
    expQ.push_back(mData[1]); tagQ.push_back("R5 back-to-back first");
    @(negedge clk);
    hostSel = 2'd1; hostAddr = 8'd2;
    expQ.push_back({24'd0, mGlitch[2]}); tagQ.push_back("R5 back-to-back second");
    @(negedge clk);
    hostRd = 1'b0;

    doRead(2'd2, 8'd0, "R3 flag clear before wrap");
    while (wrCount < 260) begin
      doWrite(pat(wrCount), 8'(wrCount * 3) ^ 8'h5A); wrCount++;
    end
    doRead(2'd2, 8'd0, "R3 R7 status after wrap");
    check({24'd0, mAddr}, 32'd4, "R3 model address after wrap");
    doRead(2'd0, 8'd4, "R10 oldest sample at write address");
    doRead(2'd0, 8'd3, "R2 newest sample overwrote slot");
    doWrite(pat(wrCount), 8'hC3); wrCount++;
    doRead(2'd2, 8'd0, "R3 flag stays set");

    // Read of the slot being written this cycle
    @(negedge clk);
    wrStrobe = 1'b1; wrData = 32'h1234_5678; wrGlitch = 8'h99;
    hostRd = 1'b1; hostSel = 2'd0; hostAddr = mAddr;
    expQ.push_back(mData[mAddr]); tagQ.push_back("R9 read-before-write");
    @(negedge clk);
    wrStrobe = 1'b0; hostRd = 1'b0;
    mData[mAddr] = 32'h1234_5678; mGlitch[mAddr] = 8'h99; mAddr = mAddr + 8'd1;
    doRead(2'd0, mAddr - 8'd1, "R2 write after same-cycle read");

    // Stop with a strobe in the same cycle, then more strobes
    @(negedge clk);
    stopReq = 1'b1; wrStrobe = 1'b1; wrData = 32'hFFFF_0000; wrGlitch = 8'hEE;
    @(negedge clk);
    stopReq = 1'b0;
    mStopped = 1;
    repeat (3) @(negedge clk);
    wrStrobe = 1'b0;
    doRead(2'd2, 8'd0, "R4 R7 stopped status, address frozen");
    doRead(2'd0, mAddr, "R4 no write while stopped");
    doRead(2'd1, mAddr, "R4 no glitch write while stopped");

    // Reset keeps memory, clears state
    doReset();
    doRead(2'd2, 8'd0, "R1 R3 R4 state cleared by reset");
    doRead(2'd0, 8'd4, "R8 sample kept over reset");
    doRead(2'd1, 8'd7, "R8 glitch kept over reset");
    doWrite(32'h0BAD_F00D, 8'h11);
    doRead(2'd0, 8'd0, "R2 write after reset at address 0");
    doRead(2'd2, 8'd0, "R7 status after restart");

    repeat (4) @(negedge clk);
    check(expQ.size(), 0, "R5 all results delivered");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule